// File: doc/BRIEF.md
# Triangular Down-Spread Profile Generator

This block produces the control word for the fractional-division modulator of a spread-spectrum clock synthesizer. It runs on the reference clock. An internal up/down counter climbs from zero to a programmed peak and then falls back to zero, over and over, so that it traces a continuous triangle. The count is scaled by a constant and subtracted from the nominal fractional division word. The output frequency therefore sweeps downward from nominal, never above it, and reaches its deepest point at the peak count.

The defaults target a 20 MHz reference, a nominal division of 60 held as 60.0 in a word with 16 fraction bits, a triangle of about 666 reference cycles (roughly a 30 kHz modulation rate) and a 5000 ppm down-spread. Those defaults are a peak of 333 counts with a step of 1 and a scale of 59 LSBs per count, giving 333 * 59 = 19647, about 0.3 of one division. When spreading is switched off, the counter rests at zero and the output stays at the nominal word.

Top module: `ssc_profile_gen`

## Requirements
- R1: A synchronous active-high reset clears the count to zero and sets the ramp direction to rising. In the cycle after reset, ctrl_word equals the nominal word NOM = NOM_INT * 2^FRAC_W.
- R2: While ssc_en is low, the count is held at zero and the direction is set to rising, so ctrl_word stays at NOM in every cycle after the edge that sampled ssc_en low.
- R3: While ssc_en is high and the ramp is rising below its top, each clock edge raises the count by exactly STEP.
- R4: On a rising ramp, when count + STEP would reach or pass PEAK, the count is set to exactly PEAK and the direction turns to falling. The count never exceeds PEAK.
- R5: On a falling ramp, when the count is at or below STEP, the count becomes exactly 0 and the direction turns to rising. In every other falling cycle, the count drops by STEP.
- R6: ctrl_word equals NOM − count * SCALE in the same cycle as the count, so the deepest point is NOM − PEAK * SCALE.
- R7: With ssc_en held high, successive visits to the deepest word are exactly 2 * ceil(PEAK / STEP) cycles apart.
- R8: ctrl_word always lies between NOM − PEAK * SCALE and NOM, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ssc_en | input | 1 | High enables the triangular spread; low holds nominal |
| ctrl_word | output | WORD_W | Fractional division control word for the modulator |

## Verification
The bench builds the block with PEAK = 10 and STEP = 3, so the step does not divide the peak evenly. This makes the clamp at the top reachable (9 goes to 10, not 12) and also the clamp at the floor (1 goes to 0, not −2), within a triangle only 8 cycles long. These short triangles allow many turnarounds, disable and re-enable events in mid-ramp, and resets in mid-ramp in a short run, while keeping the default word width and scale.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic {DIR_FALL = 1'b0, DIR_RISE = 1'b1} ramp_dir_e;

  // nominal word minus scaled count
  function automatic int unsigned spread_word(input int unsigned nom,
                                              input int unsigned cnt,
                                              input int unsigned scale);
    return nom - cnt * scale;
  endfunction

  // rising step with clamp at the top
  function automatic int unsigned rise_next(input int unsigned cnt,
                                            input int unsigned step,
                                            input int unsigned peak);
    return (cnt + step >= peak) ? peak : cnt + step;
  endfunction

  // falling step with clamp at zero
  function automatic int unsigned fall_next(input int unsigned cnt,
                                            input int unsigned step);
    return (cnt <= step) ? 0 : cnt - step;
  endfunction

endpackage

// File: rtl/ssc_ramp_ctr.sv
module ssc_ramp_ctr
  import ssc_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned PEAK  = 333,
  parameter int unsigned STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output ramp_dir_e        dir,
  output logic             top_turn,
  output logic             floor_turn
);

  logic [CNT_W-1:0] cnt_q;
  ramp_dir_e        dir_q;
  int unsigned      cnt_w;

  assign cnt_w      = 32'(cnt_q);
  assign top_turn   = run && (dir_q == DIR_RISE) && (cnt_w + STEP >= PEAK);
  assign floor_turn = run && (dir_q == DIR_FALL) && (cnt_w <= STEP);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      dir_q <= DIR_RISE;
    end else if (dir_q == DIR_RISE) begin
      cnt_q <= CNT_W'(rise_next(cnt_w, STEP, PEAK));
      if (top_turn) dir_q <= DIR_FALL;
    end else begin
      cnt_q <= CNT_W'(fall_next(cnt_w, STEP));
      if (floor_turn) dir_q <= DIR_RISE;
    end
  end

  assign cnt = cnt_q;
  assign dir = dir_q;

endmodule

// File: rtl/ssc_word_map.sv
module ssc_word_map
  import ssc_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned NOM    = 60 << 16,
  parameter int unsigned SCALE  = 59
) (
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] word
);

  assign word = WORD_W'(spread_word(NOM, 32'(cnt), SCALE));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned PEAK    = 333,
  parameter int unsigned STEP    = 1,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned NOM_INT = 60,
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned SCALE   = 59
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ssc_en,
  output logic [WORD_W-1:0] ctrl_word
);

  localparam int unsigned NOM = NOM_INT << FRAC_W;

  logic [CNT_W-1:0] cnt_q;
  ramp_dir_e        dir_q;
  logic             top_turn;
  logic             floor_turn;

  ssc_ramp_ctr #(.CNT_W(CNT_W), .PEAK(PEAK), .STEP(STEP)) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .run       (ssc_en),
    .cnt       (cnt_q),
    .dir       (dir_q),
    .top_turn  (top_turn),
    .floor_turn(floor_turn)
  );

  ssc_word_map #(.CNT_W(CNT_W), .WORD_W(WORD_W), .NOM(NOM), .SCALE(SCALE)) u_map (
    .cnt (cnt_q),
    .word(ctrl_word)
  );

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
  import ssc_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned PEAK   = 333,
  parameter int unsigned STEP   = 1,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned NOM    = 60 << 16,
  parameter int unsigned SCALE  = 59
) (
  input logic              clk,
  input logic              rst,
  input logic              ssc_en,
  input logic [CNT_W-1:0]  cnt_q,
  input ramp_dir_e         dir_q,
  input logic [WORD_W-1:0] ctrl_word
);

  localparam int unsigned DEEP = NOM - PEAK * SCALE;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (cnt_q == '0 && dir_q == DIR_RISE)); // R1
  AST_HOLD_NOMINAL: assert property (@(posedge clk) disable iff (rst) !ssc_en |=> (32'(ctrl_word) == NOM)); // R2
  AST_RISE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ssc_en && dir_q == DIR_RISE && 32'(cnt_q) + STEP < PEAK) |=> (32'(cnt_q) == 32'($past(cnt_q)) + STEP)); // R3
  AST_PEAK_EXACT: assert property (@(posedge clk) disable iff (rst)
    (ssc_en && dir_q == DIR_RISE && 32'(cnt_q) + STEP >= PEAK) |=> (32'(cnt_q) == PEAK && dir_q == DIR_FALL)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) 32'(cnt_q) <= PEAK); // R4
  AST_FLOOR_EXACT: assert property (@(posedge clk) disable iff (rst)
    (ssc_en && dir_q == DIR_FALL && 32'(cnt_q) <= STEP) |=> (cnt_q == '0 && dir_q == DIR_RISE)); // R5
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (32'(ctrl_word) <= NOM && 32'(ctrl_word) >= DEEP)); // R8

endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .CNT_W(CNT_W), .PEAK(PEAK), .STEP(STEP), .WORD_W(WORD_W),
  .NOM(NOM_INT << FRAC_W), .SCALE(SCALE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ssc_en   (ssc_en),
  .cnt_q    (cnt_q),
  .dir_q    (dir_q),
  .ctrl_word(ctrl_word)
);

// File: tb/test_ssc_profile_gen.sv
module test_ssc_profile_gen;

  localparam int unsigned PEAK   = 10;
  localparam int unsigned STEP   = 3;
  localparam int unsigned SCALE  = 59;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned NOM    = 60 * 65536;
  localparam int unsigned DEEP   = NOM - PEAK * SCALE;
  localparam int unsigned HALF   = (PEAK + STEP - 1) / STEP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ssc_en = 1'b0;
  logic [WORD_W-1:0] ctrl_word;

  always #2 clk = ~clk;

  ssc_profile_gen #(.PEAK(PEAK), .STEP(STEP), .SCALE(SCALE), .WORD_W(WORD_W)) i_ssc_profile_gen (
    .clk(clk), .rst(rst), .ssc_en(ssc_en), .ctrl_word(ctrl_word)
  );

  int unsigned exp_q[$];
  string       tag_q[$];
  int compared = 0;
  int mismatched = 0;
  int breaks = 0;
  bit done = 1'b0;

  int unsigned m_cnt = 0;
  bit          m_rise = 1'b1;

  // one cycle of stimulus plus the expected word after the next edge
  task automatic step(input bit r, input bit e);
    string t;
    @(negedge clk);
    rst = r;
    ssc_en = e;
    if (r) begin
      m_cnt = 0; m_rise = 1'b1; t = "R1"; breaks++;
    end else if (!e) begin
      m_cnt = 0; m_rise = 1'b1; t = "R2"; breaks++;
    end else if (m_rise) begin
      if (m_cnt + STEP >= PEAK) begin m_cnt = PEAK; m_rise = 1'b0; t = "R4"; end
      else begin m_cnt = m_cnt + STEP; t = "R3"; end
    end else begin
      if (m_cnt <= STEP) begin m_cnt = 0; m_rise = 1'b1; t = "R5"; end
      else begin m_cnt = m_cnt - STEP; t = "R6"; end
    end
    exp_q.push_back(NOM - SCALE * m_cnt);
    tag_q.push_back(t);
  endtask

  // monitor: compares every edge against the scoreboard
  initial begin
    int sample = 0;
    int last_deep = -1;
    int deep_breaks = 0;
    forever begin
      @(posedge clk);
      #1;
      sample++;
      if (exp_q.size() > 0) begin
        int unsigned e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (32'(ctrl_word) != e) begin
          mismatched++;
          $display("FAIL %s: ctrl_word=%0d expected=%0d", t, ctrl_word, e);
        end
        compared++;
        if (32'(ctrl_word) > NOM || 32'(ctrl_word) < DEEP) begin
          mismatched++;
          $display("FAIL R8: ctrl_word=%0d expected within %0d..%0d", ctrl_word, DEEP, NOM);
        end
        if (32'(ctrl_word) == DEEP) begin
          if (last_deep >= 0 && deep_breaks == breaks) begin
            compared++;
            if (sample - last_deep != 2 * HALF) begin
              mismatched++;
              $display("FAIL R7: period=%0d expected=%0d", sample - last_deep, 2 * HALF);
            end
          end
          last_deep = sample;
          deep_breaks = breaks;
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step(1'b1, 1'b1);
    // R3 R4 R5 R6 R7: several full triangles
    repeat (40) step(1'b0, 1'b1);
    // R2: disabled while mid-ramp
    repeat (5) step(1'b0, 1'b0);
    repeat (6) step(1'b0, 1'b1);
    // R2: disable right after peak on the falling side
    repeat (2) step(1'b0, 1'b0);
    repeat (13) step(1'b0, 1'b1);
    // R1: reset while mid-ramp and enabled
    step(1'b1, 1'b1);
    repeat (30) step(1'b0, 1'b1);
    // alternating enable pattern
    for (int i = 0; i < 20; i++) step(1'b0, i % 3 != 0);
    repeat (20) step(1'b0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule